// File: doc/BRIEF.md
# Wire-Group Track Pattern Detector

This block watches one key wire group of a six-layer chamber and decides, clock by clock, whether a track passes through it. It receives the raw hit bits of five neighbouring wire groups on every layer: the key group, the two groups below it and the two groups above it. Each bit is first stretched into a pulse of fixed length, so that hits from the same particle that arrive a few clocks apart still overlap in time.

Two layer counts are formed from the stretched bits. The collision count uses a slanted envelope of 14 positions that a mask word can thin out. The accelerator count looks only at the key group on each layer and has no mask. Each count drives its own trigger unit. When the count reaches a pre-trigger threshold, a drift counter starts. When the counter reaches the programmed drift delay and the count still meets the pattern threshold, a one-cycle strobe is issued together with a 2-bit quality. The counter then saturates, which gives each path a dead time that lasts until its count falls below the pre-trigger threshold again.

Top module: `wg_pattern_det`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both strobes and both quality outputs are 0.
- R2: A rising edge on any hit input makes that input count as present for exactly 6 clocks. An input that stays high does not extend the pulse, so a level held for 20 clocks produces one trigger per path and no more.
- R3: Hit bit l*5+k stands for layer l (0..5) and neighbour offset k, where k=0 is the key group minus 2 and k=4 is the key group plus 2. The collision envelope covers layer 0 at offsets 0..2, layer 1 at 1..2, layer 2 at 2, layer 3 at 2..3, layer 4 at 2..4 and layer 5 at 2..4. Mask bits 0..13 follow that list in the same order. A layer counts if any unmasked stretched bit of the envelope is 1. Hits outside the envelope have no effect.
- R4: The accelerator count is the number of layers whose stretched offset-2 bit is 1. The mask does not affect it.
- R5: The quality is 0 for a count of 3 or less, 1 for 4, 2 for 5 and 3 for 6.
- R6: If hits first reach the pre-trigger threshold at clock edge E, the strobe is high for the single cycle after edge E+1+d, where d is the drift delay (0 to 3).
- R7: No strobe is issued if the count at the drift-delay instant is below the pattern threshold, even when the pre-trigger threshold was met.
- R8: After a trigger, a path issues no further trigger while its count stays at or above the pre-trigger threshold. Once the count drops below that threshold, the path re-arms.
- R9: An accelerator threshold of 0 means that the matching collision threshold is used instead.
- R10: The collision path and the accelerator path each have their own drift counter and their own thresholds, and each fires independently of the other.
- R11: A quality output is 0 in every cycle in which its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits_i | input | 30 | Raw hits, bit l*5+k = layer l, offset k (k=0 is key-2) |
| coll_mask_i | input | 14 | Collision envelope enable mask, 1 = position used |
| coll_pre_thr_i | input | 3 | Collision pre-trigger layer threshold |
| coll_pat_thr_i | input | 3 | Collision pattern layer threshold |
| acc_pre_thr_i | input | 3 | Accelerator pre-trigger threshold, 0 = use collision value |
| acc_pat_thr_i | input | 3 | Accelerator pattern threshold, 0 = use collision value |
| drift_dly_i | input | 2 | Drift delay in clocks, 0 to 3 |
| coll_vld_o | output | 1 | Collision trigger strobe |
| coll_qual_o | output | 2 | Collision trigger quality |
| acc_vld_o | output | 1 | Accelerator trigger strobe |
| acc_qual_o | output | 2 | Accelerator trigger quality |

## Verification
The bench builds the block with its default parameters: a 6-clock stretch and a 3-bit saturating drift counter. With these values every drift delay from 0 to 3 falls inside one stretched pulse, and hits held or repeated within the pulse drive the counter into saturation. Staggered arrivals, a second burst that comes before and after the pulses die, and a long held level therefore separate correct dead-time handling from a counter that wraps or rearms too early. Mask bits at both ends of the envelope, and hits just outside it, show whether the envelope order and the masking are right.

// File: rtl/wgp_pkg.sv
package wgp_pkg;

    localparam int NLAYER  = 6;
    localparam int WIN     = 5;
    localparam int CENTER  = 2;
    localparam int MASK_W  = 14;
    localparam int CNT_W   = $clog2(NLAYER + 1);
    localparam int DRIFT_W = 3;
    localparam int THR_W   = 3;
    localparam int DLY_W   = 2;

    // lowest neighbour offset used by the collision envelope on a layer
    function automatic int env_lo(input int l);
        case (l)
            0:       return 0;
            1:       return 1;
            default: return 2;
        endcase
    endfunction

    // highest neighbour offset used by the collision envelope on a layer
    function automatic int env_hi(input int l);
        case (l)
            0, 1, 2: return 2;
            3:       return 3;
            default: return 4;
        endcase
    endfunction

    // first mask bit that belongs to layer l
    function automatic int mask_base(input int l);
        int acc;
        acc = 0;
        for (int i = 0; i < l; i++) begin
            acc += env_hi(i) - env_lo(i) + 1;
        end
        return acc;
    endfunction

    function automatic logic [1:0] qual_of(input logic [CNT_W-1:0] c);
        if (c >= CNT_W'(6))      return 2'd3;
        else if (c == CNT_W'(5)) return 2'd2;
        else if (c == CNT_W'(4)) return 2'd1;
        else                     return 2'd0;
    endfunction

endpackage

// File: rtl/wgp_oneshot.sv
module wgp_oneshot #(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic str_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } os_state_t;

    os_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = hit_i;
        if (hit_i && !s_q.prev) begin
            s_d.cnt = CW'(LEN);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign str_o = (s_q.cnt != '0);

endmodule

// File: rtl/wgp_layer_count.sv
module wgp_layer_count
    import wgp_pkg::*;
(
    input  logic [NLAYER*WIN-1:0] str_i,
    input  logic [MASK_W-1:0]     mask_i,
    output logic [CNT_W-1:0]      coll_cnt_o,
    output logic [CNT_W-1:0]      acc_cnt_o
);
    logic [NLAYER*WIN-1:0] sel;
    logic [NLAYER-1:0]     coll_lay;
    logic [NLAYER-1:0]     acc_lay;

    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
        for (genvar k = 0; k < WIN; k++) begin : g_off
            if (k >= env_lo(l) && k <= env_hi(l)) begin : g_in
                assign sel[l*WIN+k] = str_i[l*WIN+k] & mask_i[mask_base(l) + k - env_lo(l)];
            end else begin : g_out
                assign sel[l*WIN+k] = 1'b0;
            end
        end
        assign coll_lay[l] = |sel[l*WIN +: WIN];
        assign acc_lay[l]  = str_i[l*WIN + CENTER];
    end

    always_comb begin
        coll_cnt_o = '0;
        acc_cnt_o  = '0;
        for (int l = 0; l < NLAYER; l++) begin
            coll_cnt_o = coll_cnt_o + CNT_W'(coll_lay[l]);
            acc_cnt_o  = acc_cnt_o  + CNT_W'(acc_lay[l]);
        end
    end

endmodule

// File: rtl/wgp_trig_unit.sv
module wgp_trig_unit
    import wgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [THR_W-1:0] pre_thr_i,
    input  logic [THR_W-1:0] pat_thr_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             vld_o,
    output logic [1:0]       qual_o
);
    localparam logic [DRIFT_W-1:0] DRIFT_MAX = '1;

    typedef struct packed {
        logic [DRIFT_W-1:0] drift;
        logic               vld;
        logic [1:0]         qual;
    } tu_state_t;

    tu_state_t s_d, s_q;
    logic      above;

    always_comb begin
        above  = (CNT_W'(cnt_i) >= CNT_W'(pre_thr_i));
        s_d    = s_q;
        s_d.vld  = 1'b0;
        s_d.qual = 2'd0;
        if (!above) begin
            s_d.drift = '0;
        end else begin
            if (s_q.drift == DRIFT_W'(dly_i) && CNT_W'(cnt_i) >= CNT_W'(pat_thr_i)) begin
                s_d.vld  = 1'b1;
                s_d.qual = qual_of(cnt_i);
            end
            if (s_q.drift != DRIFT_MAX) begin
                s_d.drift = s_q.drift + DRIFT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o  = s_q.vld;
    assign qual_o = s_q.qual;

endmodule

// File: rtl/wg_pattern_det.sv
module wg_pattern_det
    import wgp_pkg::*;
#(
    parameter int STRETCH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLAYER*WIN-1:0] hits_i,
    input  logic [MASK_W-1:0]     coll_mask_i,
    input  logic [THR_W-1:0]      coll_pre_thr_i,
    input  logic [THR_W-1:0]      coll_pat_thr_i,
    input  logic [THR_W-1:0]      acc_pre_thr_i,
    input  logic [THR_W-1:0]      acc_pat_thr_i,
    input  logic [DLY_W-1:0]      drift_dly_i,
    output logic                  coll_vld_o,
    output logic [1:0]            coll_qual_o,
    output logic                  acc_vld_o,
    output logic [1:0]            acc_qual_o
);
    logic [NLAYER*WIN-1:0] stretched;
    logic [CNT_W-1:0]      coll_cnt;
    logic [CNT_W-1:0]      acc_cnt;
    logic [THR_W-1:0]      acc_pre_eff;
    logic [THR_W-1:0]      acc_pat_eff;

    for (genvar b = 0; b < NLAYER*WIN; b++) begin : g_os
        wgp_oneshot #(.LEN(STRETCH)) os_i (
            .clk   (clk),
            .rst_n (rst_n),
            .hit_i (hits_i[b]),
            .str_o (stretched[b])
        );
    end

    wgp_layer_count cnt_i (
        .str_i      (stretched),
        .mask_i     (coll_mask_i),
        .coll_cnt_o (coll_cnt),
        .acc_cnt_o  (acc_cnt)
    );

    always_comb begin
        acc_pre_eff = (acc_pre_thr_i == '0) ? coll_pre_thr_i : acc_pre_thr_i;
        acc_pat_eff = (acc_pat_thr_i == '0) ? coll_pat_thr_i : acc_pat_thr_i;
    end

    wgp_trig_unit coll_tu_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (coll_cnt),
        .pre_thr_i (coll_pre_thr_i),
        .pat_thr_i (coll_pat_thr_i),
        .dly_i     (drift_dly_i),
        .vld_o     (coll_vld_o),
        .qual_o    (coll_qual_o)
    );

    wgp_trig_unit acc_tu_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (acc_cnt),
        .pre_thr_i (acc_pre_eff),
        .pat_thr_i (acc_pat_eff),
        .dly_i     (drift_dly_i),
        .vld_o     (acc_vld_o),
        .qual_o    (acc_qual_o)
    );

endmodule

// File: rtl/wg_pattern_det_chk.sv
module wg_pattern_det_chk
    import wgp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             coll_vld,
    input logic [1:0]       coll_qual,
    input logic             acc_vld,
    input logic [1:0]       acc_qual,
    input logic [CNT_W-1:0] coll_cnt,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [THR_W-1:0] coll_pat,
    input logic [THR_W-1:0] acc_pat
);
    // R8: the saturating counter forbids back-to-back strobes
    assert_coll_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coll_vld |=> !coll_vld);
    assert_acc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> !acc_vld);

    // R11: quality is quiet without a strobe
    assert_coll_qual_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !coll_vld |-> coll_qual == 2'd0);
    assert_acc_qual_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |-> acc_qual == 2'd0);

    // R7: a strobe follows a cycle whose count met the pattern threshold
    assert_coll_pat_met_R7: assert property (@(posedge clk) disable iff (!rst_n)
        coll_vld |-> $past(CNT_W'(coll_cnt) >= CNT_W'(coll_pat)));
    assert_acc_pat_met_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> $past(CNT_W'(acc_cnt) >= CNT_W'(acc_pat)));

endmodule

bind wg_pattern_det wg_pattern_det_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .coll_vld  (coll_vld_o),
    .coll_qual (coll_qual_o),
    .acc_vld   (acc_vld_o),
    .acc_qual  (acc_qual_o),
    .coll_cnt  (coll_cnt),
    .acc_cnt   (acc_cnt),
    .coll_pat  (coll_pat_thr_i),
    .acc_pat   (acc_pat_eff)
);

// File: tb/wg_pattern_det_tb_top.sv
module wg_pattern_det_tb_top;

    localparam int NB = 30;
    localparam int NC = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] hits_i = '0;
    logic [13:0]   coll_mask_i = '1;
    logic [2:0]    coll_pre_thr_i = 3'd2;
    logic [2:0]    coll_pat_thr_i = 3'd4;
    logic [2:0]    acc_pre_thr_i = 3'd0;
    logic [2:0]    acc_pat_thr_i = 3'd0;
    logic [1:0]    drift_dly_i = 2'd0;
    logic          coll_vld_o;
    logic [1:0]    coll_qual_o;
    logic          acc_vld_o;
    logic [1:0]    acc_qual_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [NB-1:0] stim [0:NC-1];
    int c_first, c_num, c_q, a_first, a_num, a_q, leak;

    always #5 clk = ~clk;

    wg_pattern_det dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .hits_i         (hits_i),
        .coll_mask_i    (coll_mask_i),
        .coll_pre_thr_i (coll_pre_thr_i),
        .coll_pat_thr_i (coll_pat_thr_i),
        .acc_pre_thr_i  (acc_pre_thr_i),
        .acc_pat_thr_i  (acc_pat_thr_i),
        .drift_dly_i    (drift_dly_i),
        .coll_vld_o     (coll_vld_o),
        .coll_qual_o    (coll_qual_o),
        .acc_vld_o      (acc_vld_o),
        .acc_qual_o     (acc_qual_o)
    );

    function automatic int hb(input int l, input int k);
        return l * 5 + k;
    endfunction

    function automatic logic [NB-1:0] at_key(input int nl);
        logic [NB-1:0] v;
        v = '0;
        for (int l = 0; l < nl; l++) v[hb(l, 2)] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_stim();
        for (int i = 0; i < NC; i++) stim[i] = '0;
    endtask

    // drive stim[i] before edge Ei, sample after it; index i = cycle after Ei
    task automatic play();
        c_first = -1; c_num = 0; c_q = -1;
        a_first = -1; a_num = 0; a_q = -1; leak = 0;
        for (int i = 0; i < NC; i++) begin
            hits_i = stim[i];
            @(posedge clk);
            @(negedge clk);
            if (coll_vld_o) begin
                if (c_first < 0) begin c_first = i; c_q = int'(coll_qual_o); end
                c_num++;
            end else if (coll_qual_o != 2'd0) leak++;
            if (acc_vld_o) begin
                if (a_first < 0) begin a_first = i; a_q = int'(acc_qual_o); end
                a_num++;
            end else if (acc_qual_o != 2'd0) leak++;
        end
        hits_i = '0;
        clr_stim();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 coll_vld in reset", int'(coll_vld_o), 0);
        chk("R1 acc_vld in reset", int'(acc_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 coll_vld after reset", int'(coll_vld_o), 0);
        chk("R1 qual after reset", int'(coll_qual_o) + int'(acc_qual_o), 0);
    endtask

    task automatic t_delay_sweep();
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd4;
        acc_pre_thr_i = 3'd0; acc_pat_thr_i = 3'd0;
        for (int d = 0; d < 4; d++) begin
            drift_dly_i = 2'(d);
            clr_stim();
            stim[0] = at_key(6);
            play();
            chk("R6 coll strobe cycle", c_first, 1 + d);
            chk("R6 coll single strobe", c_num, 1);
            chk("R9 acc fallback strobe cycle", a_first, 1 + d);
            chk("R5 six-layer quality", c_q, 3);
            chk("R11 no quality leak", leak, 0);
        end
    endtask

    task automatic t_quality();
        coll_pre_thr_i = 3'd1; coll_pat_thr_i = 3'd1; drift_dly_i = 2'd1;
        for (int n = 1; n <= 6; n++) begin
            clr_stim();
            stim[0] = at_key(n);
            play();
            chk("R5 strobe present", c_first, 2);
            chk("R5 quality for count", c_q, (n <= 3) ? 0 : n - 3);
            chk("R4 acc quality for count", a_q, (n <= 3) ? 0 : n - 3);
        end
    endtask

    task automatic t_mask();
        logic [NB-1:0] v;
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd4; drift_dly_i = 2'd0;
        acc_pre_thr_i = 3'd0; acc_pat_thr_i = 3'd0;
        v = '0;
        v[hb(0, 0)] = 1'b1;
        v[hb(1, 1)] = 1'b1;
        v[hb(4, 4)] = 1'b1;
        v[hb(5, 4)] = 1'b1;
        v[hb(2, 1)] = 1'b1;
        v[hb(3, 4)] = 1'b1;
        coll_mask_i = '1;
        clr_stim(); stim[0] = v; play();
        chk("R3 envelope edges count four", c_first, 1);
        chk("R3 envelope quality", c_q, 1);
        chk("R4 off-key hits ignored by acc", a_num, 0);
        coll_mask_i = '1; coll_mask_i[0] = 1'b0;
        clr_stim(); stim[0] = v; play();
        chk("R3 mask bit0 removes layer0", c_num, 0);
        coll_mask_i = '1; coll_mask_i[13] = 1'b0;
        clr_stim(); stim[0] = v; play();
        chk("R3 mask bit13 removes layer5", c_num, 0);
        coll_mask_i = '0;
        clr_stim(); stim[0] = at_key(6); play();
        chk("R4 mask does not affect acc", a_q, 3);
        chk("R3 empty mask no coll", c_num, 0);
        coll_mask_i = '1;
    endtask

    task automatic t_below_pattern();
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd4; drift_dly_i = 2'd2;
        clr_stim(); stim[0] = at_key(3); play();
        chk("R7 pretrig without pattern coll", c_num, 0);
        chk("R7 pretrig without pattern acc", a_num, 0);
    endtask

    task automatic t_staggered();
        logic [NB-1:0] v;
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd4; drift_dly_i = 2'd2;
        clr_stim();
        stim[0] = at_key(2);
        v = '0; v[hb(2, 2)] = 1'b1; v[hb(3, 2)] = 1'b1;
        stim[1] = v;
        play();
        chk("R6 staggered strobe cycle", c_first, 3);
        chk("R7 staggered quality", c_q, 1);
    endtask

    task automatic t_dead_time();
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd4; drift_dly_i = 2'd1;
        clr_stim(); stim[0] = at_key(6); stim[4] = at_key(6); play();
        chk("R8 overlapping burst one coll", c_num, 1);
        chk("R8 overlapping burst one acc", a_num, 1);
        clr_stim(); stim[0] = at_key(6); stim[8] = at_key(6); play();
        chk("R8 rearm two coll", c_num, 2);
        chk("R8 rearm two acc", a_num, 2);
        clr_stim();
        for (int i = 0; i < 20; i++) stim[i] = at_key(6);
        play();
        chk("R2 held level one trigger", c_num, 1);
        chk("R2 held level one acc trigger", a_num, 1);
    endtask

    task automatic t_independent();
        coll_pre_thr_i = 3'd2; coll_pat_thr_i = 3'd6;
        acc_pre_thr_i = 3'd2; acc_pat_thr_i = 3'd3; drift_dly_i = 2'd0;
        clr_stim(); stim[0] = at_key(4); play();
        chk("R10 coll silent", c_num, 0);
        chk("R10 acc fires alone", a_first, 1);
        chk("R10 acc quality", a_q, 1);
        acc_pre_thr_i = 3'd5; acc_pat_thr_i = 3'd5; coll_pat_thr_i = 3'd3;
        clr_stim(); stim[0] = at_key(4); play();
        chk("R10 coll fires alone", c_first, 1);
        chk("R9 nonzero acc threshold honoured", a_num, 0);
        acc_pre_thr_i = 3'd0; acc_pat_thr_i = 3'd0;
    endtask

    initial begin
        clr_stim();
        t_reset();
        t_delay_sweep();
        t_quality();
        t_mask();
        t_below_pattern();
        t_staggered();
        t_dead_time();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule